// File: doc/BRIEF.md
# Dual-Channel Temperature Limit Monitor

This block watches two temperature readings, one from the die itself (local) and one from an external sensing point (remote). Each reading is checked against its own high, low and critical thresholds. A status word records which channel broke which limit. The block drives an active-low alert output and a separate critical output. The local reading is in whole degrees. The remote reading adds a 3-bit eighth-of-a-degree fraction, and that fraction takes part in the remote high and low comparisons.

A sensor front end presents one new pair of readings per conversion through a valid strobe. A host programs the thresholds through a byte-wide write port. A read strobe on the status word marks the moment the host has consumed the alarms.

High, low and open-sensor alarms are sticky. A critical alarm follows a hysteresis band: one relative delta is shared by both channels. The alert output is qualified by a programmable count of consecutive out-of-limit samples and can be masked. All temperatures and limits are two's complement.

Top module: `thermal_limit_monitor`

## Requirements
- R1: After reset the status word is 0, `alert_n` is 1 and `crit_out` is 0. The reset thresholds are: high 127, low -128, critical 127, both fractions 0, hysteresis 10, consecutive count 1, mask 0. Status bit 7 always reads 0.
- R2: A write with `wr_en` high loads the register at `wr_addr`: 0 config (bit 0 = alert mask), 1 local high, 2 local low, 3 local critical, 4 remote high, 5 remote low, 6 remote critical, 7 hysteresis (unsigned), 8 remote high fraction (bits 2:0), 9 remote low fraction (bits 2:0), 10 consecutive count (bits 2:0). Other addresses are ignored.
- R3: A sample whose local reading is strictly greater than the local high limit sets status bit 0. Equality does not set it.
- R4: A sample strictly below the low limit sets the low flag: bit 1 for local, bit 4 for remote. The remote test compares the 11-bit value {integer, fraction} with {low limit, low fraction}.
- R5: A remote sample sets bit 3 when {integer, fraction} is strictly greater than {remote high, high fraction}.
- R6: A sample whose integer reading exceeds that channel's critical limit sets its critical flag (bit 2 local, bit 5 remote). The remote fraction is ignored here. `crit_out` is the OR of the two critical flags.
- R7: A critical flag stays set until a sample arrives at or below that channel's critical limit minus the shared hysteresis.
- R8: Bits 0, 1, 3, 4 and 6 are sticky. A status read clears only those bits whose condition was absent in the most recent sample.
- R9: A sample taken with `remote_open` high sets status bit 6.
- R10: An out-of-limit sample is one that is over high, under low, over critical or open. `alert_n` goes low on the N-th such sample in a row, where N is the count register (0 acts as 1). A clean sample restarts the run.
- R11: Once the status word becomes all zero, `alert_n` returns high. `alert_n` is never low while the status word is zero.
- R12: With the mask bit set, `alert_n` is held high while the flags keep updating. Clearing the mask brings back a pending alert.
- R13: Every result of a sample, read or write appears after the clock edge that captures it, never earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sample_valid | input | 1 | Qualifies one new pair of readings |
| local_temp | input | TEMP_W | Local reading, whole degrees |
| remote_temp | input | TEMP_W | Remote reading, integer degrees |
| remote_frac | input | FRAC_W | Remote reading, eighths of a degree |
| remote_open | input | 1 | Remote sensor fault for this sample |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | TEMP_W | Register write data |
| status_rd | input | 1 | Host consumed the status word |
| status | output | 8 | Alarm flags |
| alert_n | output | 1 | Active-low alert |
| crit_out | output | 1 | Critical condition on either channel |

## Verification
Sample, read and write results are all registered on the capturing edge. Each becomes visible one edge later, with no further delay. The bench therefore drives stimulus on the falling edge and compares all outputs 2 ns after the next rising edge, against a model computed from the requirements. One dedicated check probes the outputs between the drive and the capturing edge to confirm nothing moves early. Sweeps cover every local value and every remote integer and fraction pair around the limits, and run the critical hysteresis up and down. Count and mask cases are checked sample by sample.

// File: rtl/tlm_pkg.sv
`timescale 1ns/1ps
// Package: shared register addresses and status bit layout for the
// temperature limit monitor. Assumes an 8-bit status word.
package tlm_pkg;
    localparam int unsigned ADDR_W = 4;
    localparam int unsigned ST_W   = 8;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_CFG      = 4'd0,
        ADDR_LOC_HI   = 4'd1,
        ADDR_LOC_LO   = 4'd2,
        ADDR_LOC_CRIT = 4'd3,
        ADDR_REM_HI   = 4'd4,
        ADDR_REM_LO   = 4'd5,
        ADDR_REM_CRIT = 4'd6,
        ADDR_HYST     = 4'd7,
        ADDR_REM_HI_F = 4'd8,
        ADDR_REM_LO_F = 4'd9,
        ADDR_FLT_CNT  = 4'd10
    } reg_addr_e;

    localparam int unsigned ST_LOC_HI   = 0;
    localparam int unsigned ST_LOC_LO   = 1;
    localparam int unsigned ST_LOC_CRIT = 2;
    localparam int unsigned ST_REM_HI   = 3;
    localparam int unsigned ST_REM_LO   = 4;
    localparam int unsigned ST_REM_CRIT = 5;
    localparam int unsigned ST_REM_OPEN = 6;

    localparam logic [ST_W-1:0] STICKY_MASK =
        ST_W'((1 << ST_LOC_HI) | (1 << ST_LOC_LO) | (1 << ST_REM_HI) |
              (1 << ST_REM_LO) | (1 << ST_REM_OPEN));
endpackage

// File: rtl/tlm_regfile.sv
`timescale 1ns/1ps
// Module: tlm_regfile
// Holds the programmable thresholds, hysteresis, consecutive count and
// alert mask. Index 0 of each array is the local channel, index 1 the
// remote channel. Assumes single-cycle writes with no read-back path.
module tlm_regfile
    import tlm_pkg::*;
#(
    parameter int unsigned TEMP_W   = 8,
    parameter int unsigned FRAC_W   = 3,
    parameter int unsigned CNT_W    = 3,
    parameter int unsigned HYST_RST = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TEMP_W-1:0] wr_data,
    output logic              alert_mask,
    output logic [TEMP_W-1:0] hi_lim   [2],
    output logic [TEMP_W-1:0] lo_lim   [2],
    output logic [TEMP_W-1:0] crit_lim [2],
    output logic [FRAC_W-1:0] rem_hi_frac,
    output logic [FRAC_W-1:0] rem_lo_frac,
    output logic [TEMP_W-1:0] hyst,
    output logic [CNT_W-1:0]  fault_cnt
);
    localparam logic [TEMP_W-1:0] T_MAX = {1'b0, {(TEMP_W-1){1'b1}}};
    localparam logic [TEMP_W-1:0] T_MIN = {1'b1, {(TEMP_W-1){1'b0}}};

    // Load the addressed register on a write; restore defaults on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alert_mask  <= 1'b0;
            hi_lim[0]   <= T_MAX;
            hi_lim[1]   <= T_MAX;
            lo_lim[0]   <= T_MIN;
            lo_lim[1]   <= T_MIN;
            crit_lim[0] <= T_MAX;
            crit_lim[1] <= T_MAX;
            rem_hi_frac <= '0;
            rem_lo_frac <= '0;
            hyst        <= TEMP_W'(HYST_RST);
            fault_cnt   <= CNT_W'(1);
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                ADDR_CFG:      alert_mask  <= wr_data[0];
                ADDR_LOC_HI:   hi_lim[0]   <= wr_data;
                ADDR_LOC_LO:   lo_lim[0]   <= wr_data;
                ADDR_LOC_CRIT: crit_lim[0] <= wr_data;
                ADDR_REM_HI:   hi_lim[1]   <= wr_data;
                ADDR_REM_LO:   lo_lim[1]   <= wr_data;
                ADDR_REM_CRIT: crit_lim[1] <= wr_data;
                ADDR_HYST:     hyst        <= wr_data;
                ADDR_REM_HI_F: rem_hi_frac <= wr_data[FRAC_W-1:0];
                ADDR_REM_LO_F: rem_lo_frac <= wr_data[FRAC_W-1:0];
                ADDR_FLT_CNT:  fault_cnt   <= wr_data[CNT_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/tlm_channel.sv
`timescale 1ns/1ps
// Module: tlm_channel
// Compares one channel's reading with its high, low and critical limits,
// and keeps the critical state with a release point of critical - hyst.
// Assumes two's complement readings and limits, an unsigned hysteresis,
// and fixed-point {integer, fraction} for the high and low tests.
module tlm_channel #(
    parameter int unsigned TEMP_W = 8,
    parameter int unsigned FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [TEMP_W-1:0] temp,
    input  logic [FRAC_W-1:0] frac,
    input  logic [TEMP_W-1:0] hi_lim,
    input  logic [FRAC_W-1:0] hi_frac,
    input  logic [TEMP_W-1:0] lo_lim,
    input  logic [FRAC_W-1:0] lo_frac,
    input  logic [TEMP_W-1:0] crit_lim,
    input  logic [TEMP_W-1:0] hyst,
    output logic              over_hi,
    output logic              under_lo,
    output logic              over_crit,
    output logic              crit_d,
    output logic              crit_q
);
    localparam int unsigned FX_W  = TEMP_W + FRAC_W;
    localparam int unsigned EXT_W = TEMP_W + 2;

    logic signed [FX_W-1:0]  t_fx, hi_fx, lo_fx;
    logic signed [EXT_W-1:0] t_ext, crit_ext, release_lvl;

    // Fixed-point views for the high and low tests.
    assign t_fx  = $signed({temp, frac});
    assign hi_fx = $signed({hi_lim, hi_frac});
    assign lo_fx = $signed({lo_lim, lo_frac});

    // Widened integer views so critical minus hysteresis cannot wrap.
    assign t_ext       = $signed({{2{temp[TEMP_W-1]}}, temp});
    assign crit_ext    = $signed({{2{crit_lim[TEMP_W-1]}}, crit_lim});
    assign release_lvl = crit_ext - $signed({2'b00, hyst});

    // Strict-inequality limit tests on the current inputs.
    assign over_hi   = t_fx > hi_fx;
    assign under_lo  = t_fx < lo_fx;
    assign over_crit = t_ext > crit_ext;

    // Next critical state: set above the limit, release at or below the band.
    always_comb begin
        crit_d = crit_q;
        if (sample_valid) begin
            if (!crit_q && over_crit)
                crit_d = 1'b1;
            else if (crit_q && (t_ext <= release_lvl))
                crit_d = 1'b0;
        end
    end

    // Critical state register.
    always_ff @(posedge clk) begin
        if (!rst_n) crit_q <= 1'b0;
        else        crit_q <= crit_d;
    end

    // A critical flag only rises on a sample that is over the limit.
    assert_crit_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crit_q) |-> $past(sample_valid && over_crit));

    // Inside the hysteresis band the critical flag holds.
    assert_crit_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (crit_q && !(sample_valid && (t_ext <= release_lvl))) |=> crit_q);
endmodule

// File: rtl/tlm_status.sv
`timescale 1ns/1ps
// Module: tlm_status
// Keeps the sticky alarm flags, the run of consecutive out-of-limit
// samples and the armed alert state, and drives the alert output.
// Assumes the critical states come from the channels as current and
// next values, so the armed state clears in the same cycle as the flags.
module tlm_status
    import tlm_pkg::*;
#(
    parameter int unsigned CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sample_valid,
    input  logic             status_rd,
    input  logic [1:0]       over_hi,
    input  logic [1:0]       under_lo,
    input  logic [1:0]       over_crit,
    input  logic [1:0]       crit_d,
    input  logic [1:0]       crit_q,
    input  logic             remote_open,
    input  logic [CNT_W-1:0] fault_cnt,
    input  logic             alert_mask,
    output logic [ST_W-1:0]  status,
    output logic             alert_n
);
    logic [ST_W-1:0]  cond_now, last_q, sticky_q, sticky_d, clr_mask;
    logic [ST_W-1:0]  crit_now_bits, crit_next_bits, flags_d;
    logic [CNT_W-1:0] run_q, run_d, need;
    logic             armed_q, armed_d, any_out;

    // Place the sticky conditions of this sample at their status positions.
    always_comb begin
        cond_now              = '0;
        cond_now[ST_LOC_HI]   = over_hi[0];
        cond_now[ST_LOC_LO]   = under_lo[0];
        cond_now[ST_REM_HI]   = over_hi[1];
        cond_now[ST_REM_LO]   = under_lo[1];
        cond_now[ST_REM_OPEN] = remote_open;
    end

    // Place the current and next critical states at their status positions.
    always_comb begin
        crit_now_bits              = '0;
        crit_now_bits[ST_LOC_CRIT] = crit_q[0];
        crit_now_bits[ST_REM_CRIT] = crit_q[1];
        crit_next_bits              = '0;
        crit_next_bits[ST_LOC_CRIT] = crit_d[0];
        crit_next_bits[ST_REM_CRIT] = crit_d[1];
    end

    // Next sticky flags: a read drops flags absent last sample; a sample sets.
    always_comb begin
        clr_mask = status_rd ? (~last_q & STICKY_MASK) : '0;
        sticky_d = (sticky_q & ~clr_mask) | (sample_valid ? cond_now : '0);
    end

    // Next run length and armed state for the consecutive-count rule.
    always_comb begin
        any_out = (|cond_now) | (|over_crit);
        need    = (fault_cnt == '0) ? CNT_W'(1) : fault_cnt;
        run_d   = run_q;
        if (sample_valid)
            run_d = any_out ? ((run_q == '1) ? run_q : run_q + 1'b1) : '0;
        flags_d = sticky_d | crit_next_bits;
        if (flags_d == '0)
            armed_d = 1'b0;
        else
            armed_d = armed_q | (sample_valid && any_out && (run_d >= need));
    end

    // Flag, last-condition, run and armed registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sticky_q <= '0;
            last_q   <= '0;
            run_q    <= '0;
            armed_q  <= 1'b0;
        end else begin
            sticky_q <= sticky_d;
            last_q   <= sample_valid ? cond_now : last_q;
            run_q    <= run_d;
            armed_q  <= armed_d;
        end
    end

    assign status  = sticky_q | crit_now_bits;
    assign alert_n = !(armed_q && !alert_mask);

    // Without a read, no sticky flag may drop.
    assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !status_rd |=> (($past(sticky_q) & ~sticky_q) == '0));

    // An armed alert always has a flag behind it.
    assert_alert_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> (status != '0));

    // A clean sample restarts the consecutive run.
    assert_run_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_valid && !any_out) |=> (run_q == '0));
endmodule

// File: rtl/thermal_limit_monitor.sv
`timescale 1ns/1ps
// Module: thermal_limit_monitor
// Top level of the dual-channel limit monitor: register file, one compare
// channel per sensor (local has its fraction tied to zero) and the status
// and alert logic. Assumes readings arrive at most once per cycle.
module thermal_limit_monitor
    import tlm_pkg::*;
#(
    parameter int unsigned TEMP_W = 8,
    parameter int unsigned FRAC_W = 3,
    parameter int unsigned CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_valid,
    input  logic [TEMP_W-1:0] local_temp,
    input  logic [TEMP_W-1:0] remote_temp,
    input  logic [FRAC_W-1:0] remote_frac,
    input  logic              remote_open,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [TEMP_W-1:0] wr_data,
    input  logic              status_rd,
    output logic [ST_W-1:0]   status,
    output logic              alert_n,
    output logic              crit_out
);
    logic              alert_mask;
    logic [TEMP_W-1:0] hi_lim [2];
    logic [TEMP_W-1:0] lo_lim [2];
    logic [TEMP_W-1:0] crit_lim [2];
    logic [FRAC_W-1:0] rem_hi_frac, rem_lo_frac;
    logic [TEMP_W-1:0] hyst;
    logic [CNT_W-1:0]  fault_cnt;

    logic [TEMP_W-1:0] temp_arr [2];
    logic [FRAC_W-1:0] frac_arr [2];
    logic [FRAC_W-1:0] hi_frac_arr [2];
    logic [FRAC_W-1:0] lo_frac_arr [2];
    logic [1:0]        over_hi, under_lo, over_crit, crit_d, crit_q;

    tlm_regfile #(.TEMP_W(TEMP_W), .FRAC_W(FRAC_W), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .alert_mask(alert_mask), .hi_lim(hi_lim),
        .lo_lim(lo_lim), .crit_lim(crit_lim), .rem_hi_frac(rem_hi_frac),
        .rem_lo_frac(rem_lo_frac), .hyst(hyst), .fault_cnt(fault_cnt)
    );

    // Per-channel inputs; the local channel has whole-degree resolution.
    assign temp_arr[0]    = local_temp;
    assign temp_arr[1]    = remote_temp;
    assign frac_arr[0]    = '0;
    assign frac_arr[1]    = remote_frac;
    assign hi_frac_arr[0] = '0;
    assign hi_frac_arr[1] = rem_hi_frac;
    assign lo_frac_arr[0] = '0;
    assign lo_frac_arr[1] = rem_lo_frac;

    for (genvar c = 0; c < 2; c++) begin : g_chan
        tlm_channel #(.TEMP_W(TEMP_W), .FRAC_W(FRAC_W)) u_chan (
            .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
            .temp(temp_arr[c]), .frac(frac_arr[c]),
            .hi_lim(hi_lim[c]), .hi_frac(hi_frac_arr[c]),
            .lo_lim(lo_lim[c]), .lo_frac(lo_frac_arr[c]),
            .crit_lim(crit_lim[c]), .hyst(hyst),
            .over_hi(over_hi[c]), .under_lo(under_lo[c]),
            .over_crit(over_crit[c]), .crit_d(crit_d[c]), .crit_q(crit_q[c])
        );
    end

    tlm_status #(.CNT_W(CNT_W)) u_status (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .status_rd(status_rd), .over_hi(over_hi), .under_lo(under_lo),
        .over_crit(over_crit), .crit_d(crit_d), .crit_q(crit_q),
        .remote_open(remote_open), .fault_cnt(fault_cnt),
        .alert_mask(alert_mask), .status(status), .alert_n(alert_n)
    );

    assign crit_out = |crit_q;

    // While masked, the alert pin stays released.
    assert_mask_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (alert_mask && $past(alert_mask)) |-> alert_n);
endmodule

// File: tb/sim_thermal_limit_monitor.sv
`timescale 1ns/1ps
// Bench: sweeps the monitor against an arithmetic model of the requirements.
module sim_thermal_limit_monitor;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sample_valid = 1'b0;
    logic [7:0] local_temp = '0, remote_temp = '0;
    logic [2:0] remote_frac = '0;
    logic       remote_open = 1'b0;
    logic       wr_en = 1'b0;
    logic [3:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       status_rd = 1'b0;
    logic [7:0] status;
    logic       alert_n, crit_out;

    always #10 clk = ~clk;

    thermal_limit_monitor u0 (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid),
        .local_temp(local_temp), .remote_temp(remote_temp),
        .remote_frac(remote_frac), .remote_open(remote_open),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .status_rd(status_rd), .status(status), .alert_n(alert_n),
        .crit_out(crit_out)
    );

    int errors = 0, checks = 0;
    bit done = 0;

    // Model state
    int m_lhi = 127, m_llo = -128, m_lcr = 127;
    int m_rhi = 127, m_rlo = -128, m_rcr = 127;
    int m_rhf = 0, m_rlf = 0, m_hyst = 10, m_cnt = 1, m_mask = 0;
    bit m_lcrit = 0, m_rcrit = 0, m_armed = 0;
    logic [7:0] m_sticky = '0, m_last = '0, m_status = '0;
    int m_run = 0;

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic string bit_tag(int i);
        case (i)
            0: return "R3 local high bit0";
            1: return "R4 local low bit1";
            2: return "R6 local crit bit2";
            3: return "R5 remote high bit3";
            4: return "R4 remote low bit4";
            5: return "R6 remote crit bit5";
            6: return "R9 open bit6";
            default: return "R1 bit7 zero";
        endcase
    endfunction

    task automatic compose();
        m_status = m_sticky;
        m_status[2] = m_lcrit;
        m_status[5] = m_rcrit;
        if (m_status == 8'h00) m_armed = 0;
    endtask

    task automatic check_all();
        for (int i = 0; i < 8; i++) chk(bit_tag(i), int'(status[i]), int'(m_status[i]));
        chk("R10 alert_n", int'(alert_n), int'(!(m_armed && m_mask == 0)));
        chk("R6 crit_out", int'(crit_out), int'(m_lcrit | m_rcrit));
    endtask

    task automatic model_sample(int l, int r, int f, bit op);
        bit lh, ll, rh, rl, lx, rx, out;
        int need;
        logic [7:0] c;
        lh = l > m_lhi;
        ll = l < m_llo;
        rh = (r * 8 + f) > (m_rhi * 8 + m_rhf);
        rl = (r * 8 + f) < (m_rlo * 8 + m_rlf);
        lx = l > m_lcr;
        rx = r > m_rcr;
        c = '0;
        c[0] = lh; c[1] = ll; c[3] = rh; c[4] = rl; c[6] = op;
        if (!m_lcrit && lx) m_lcrit = 1;
        else if (m_lcrit && l <= m_lcr - m_hyst) m_lcrit = 0;
        if (!m_rcrit && rx) m_rcrit = 1;
        else if (m_rcrit && r <= m_rcr - m_hyst) m_rcrit = 0;
        m_sticky = m_sticky | c;
        m_last = c;
        out = lh | ll | rh | rl | lx | rx | op;
        m_run = out ? ((m_run < 7) ? m_run + 1 : 7) : 0;
        need = (m_cnt == 0) ? 1 : m_cnt;
        if (out && m_run >= need) m_armed = 1;
        compose();
    endtask

    task automatic do_sample(int l, int r, int f, bit op);
        @(negedge clk);
        sample_valid = 1; local_temp = l[7:0]; remote_temp = r[7:0];
        remote_frac = f[2:0]; remote_open = op;
        @(posedge clk); #2;
        sample_valid = 0; remote_open = 0;
        model_sample(l, r, f, op);
        check_all();
    endtask

    task automatic do_read();
        @(negedge clk);
        status_rd = 1;
        @(posedge clk); #2;
        status_rd = 0;
        m_sticky = m_sticky & m_last;
        compose();
        check_all();
    endtask

    task automatic do_write(int a, int d);
        logic [7:0] b;
        b = d[7:0];
        @(negedge clk);
        wr_en = 1; wr_addr = a[3:0]; wr_data = b;
        @(posedge clk); #2;
        wr_en = 0;
        case (a)
            0: m_mask = int'(b[0]);
            1: m_lhi = int'($signed(b));
            2: m_llo = int'($signed(b));
            3: m_lcr = int'($signed(b));
            4: m_rhi = int'($signed(b));
            5: m_rlo = int'($signed(b));
            6: m_rcr = int'($signed(b));
            7: m_hyst = int'(b);
            8: m_rhf = int'(b[2:0]);
            9: m_rlf = int'(b[2:0]);
            10: m_cnt = int'(b[2:0]);
            default: ;
        endcase
        check_all();
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        chk("R1 status after reset", int'(status), 0);
        chk("R1 alert_n after reset", int'(alert_n), 1);
        chk("R1 crit_out after reset", int'(crit_out), 0);
        do_sample(127, 127, 0, 0);   // R1 defaults: nothing exceeded

        // Local sweep across high and low limits (R3, R4).
        do_write(1, 40);
        do_write(2, -10);
        for (int t = -128; t < 128; t++) begin
            do_sample(t, 0, 0, 0);
            do_read();
        end
        for (int t = 127; t >= -128; t--) do_sample(t, 0, 0, 0);
        do_read();

        // Remote sweep over integer and fraction (R4, R5).
        do_write(1, 127);
        do_write(2, -128);
        do_write(4, 20);
        do_write(8, 5);
        do_write(5, -3);
        do_write(9, 2);
        do_read();
        for (int r = -128; r < 128; r++) begin
            for (int f = 0; f < 8; f++) begin
                do_sample(0, r, f, 0);
                do_read();
            end
        end

        // Critical hysteresis on both channels (R6, R7).
        do_write(4, 127);
        do_write(8, 7);
        do_write(5, -128);
        do_write(9, 0);
        do_write(3, 50);
        do_write(6, 30);
        do_write(7, 5);
        do_read();
        for (int t = 40; t <= 60; t++) do_sample(t, 0, 0, 0);
        for (int t = 60; t >= 40; t--) begin
            do_sample(t, 0, 0, 0);
            chk("R7 local release point", int'(crit_out), int'(t > 45));
        end
        do_sample(0, 30, 7, 0);
        chk("R6 remote fraction ignored for crit", int'(status[5]), 0);
        do_write(7, 0);
        for (int r = 20; r <= 40; r++) do_sample(0, r, 7, 0);
        for (int r = 40; r >= 20; r--) begin
            do_sample(0, r, 7, 0);
            chk("R7 shared hysteresis zero", int'(crit_out), int'(r > 30));
        end
        do_write(7, 3);
        do_sample(0, 31, 0, 0);
        do_sample(0, 28, 0, 0);
        chk("R7 remote held in band", int'(crit_out), 1);
        do_sample(0, 27, 0, 0);
        chk("R7 remote released", int'(crit_out), 0);
        do_read();

        // Consecutive count (R10, R11).
        do_write(1, 40);
        do_write(10, 3);
        do_read();
        do_sample(50, 0, 0, 0); chk("R10 run 1", int'(alert_n), 1);
        do_sample(50, 0, 0, 0); chk("R10 run 2", int'(alert_n), 1);
        do_sample(0, 0, 0, 0);  chk("R10 clean restarts", int'(alert_n), 1);
        do_sample(50, 0, 0, 0); chk("R10 run 1 again", int'(alert_n), 1);
        do_sample(50, 0, 0, 0); chk("R10 run 2 again", int'(alert_n), 1);
        do_sample(50, 0, 0, 0); chk("R10 run 3 asserts", int'(alert_n), 0);
        do_read();
        chk("R8 read keeps present condition", int'(status[0]), 1);
        do_sample(0, 0, 0, 0);
        chk("R8 sticky after clean sample", int'(status[0]), 1);
        do_read();
        chk("R8 read clears absent condition", int'(status[0]), 0);
        chk("R11 alert released with flags", int'(alert_n), 1);
        do_write(10, 0);
        do_sample(50, 0, 0, 0);
        chk("R10 count zero acts as one", int'(alert_n), 0);

        // Mask (R12, R2).
        do_write(0, 1);
        chk("R2 cfg bit0 is mask", int'(alert_n), 1);
        do_write(2, -10);
        do_sample(-20, 0, 0, 0);
        chk("R12 flags update while masked", int'(status[1]), 1);
        chk("R12 alert held while masked", int'(alert_n), 1);
        do_write(0, 0);
        chk("R12 pending alert returns", int'(alert_n), 0);
        do_write(15, 99);   // R2 unused address ignored
        do_sample(0, 0, 0, 0);
        do_read();

        // Remote open (R9, R8).
        do_write(10, 1);
        do_sample(0, 0, 0, 1);
        chk("R9 open sets bit6", int'(status[6]), 1);
        chk("R9 open asserts alert", int'(alert_n), 0);
        do_read();
        chk("R8 open kept while present", int'(status[6]), 1);
        do_sample(0, 0, 0, 0);
        do_read();
        chk("R8 open cleared after read", int'(status[6]), 0);

        // Nothing moves before the capturing edge (R13).
        @(negedge clk);
        sample_valid = 1; local_temp = 8'd100;
        remote_temp = 8'd0; remote_frac = 3'd0; remote_open = 0;
        #5;
        chk("R13 no change before edge", int'(status), int'(m_status));
        @(posedge clk); #2;
        sample_valid = 0;
        model_sample(100, 0, 0, 0);
        check_all();
        chk("R13 result after edge", int'(status[0]), 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule